// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Router Node

This block is the switching point that sits at one corner of a binary hypercube of 2^DIM nodes. Messages enter it on one incoming link per dimension or from the node's own injection port. For each one it forms the bitwise difference between the node's own address and the message's destination. It then sends the message on the link of the lowest dimension in which the two still differ. When nothing differs, it hands the message to the node's delivery port. Each node repeats this choice with its own address, so a message fixes its address bits from the lowest upward and travels a shortest path.

Every input also shows, through a combinational hop-count output, how many hops its current message still needs. That count is the number of ones in the difference. The outputs are DIM link ports and one delivery port, and each holds a one-entry register. An input whose target register is full sees ready low and keeps its message until the register drains. Inputs that compete for one free register are served lowest index first: links in ascending dimension, then the injection port.

Top module: `hcube_router`

## Requirements
- R1: A message whose destination equals node_id_i leaves on the delivery port, with dlv_dst_o equal to node_id_i. It never leaves on a link.
- R2: A message whose destination differs from node_id_i leaves on link k, where k is the index of the lowest bit set in node_id_i XOR destination. Link k connects to the neighbour whose address has bit k inverted.
- R3: For input i, the field hops_o[i*HW +: HW] equals the number of ones in node_id_i XOR that input's destination. Index i runs 0..DIM-1 for links and is DIM for the injection port. The field is 0 for a message already at its destination.
- R4: In a full hypercube of these nodes, a message from src to dst crosses exactly popcount(src XOR dst) links. The dimensions it uses rise strictly along its path.
- R5: An input's ready is high only while its valid is high and its target output register is empty. No message is lost or duplicated, and each injected message is delivered exactly once with its payload unchanged.
- R6: While an output has valid high and ready low, its valid, destination and payload stay unchanged into the next cycle.
- R7: While rst_ni is low, every link output valid and the delivery valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| node_id_i | input | DIM | This node's hypercube address |
| lnk_in_valid_i | input | DIM | Incoming message valid, one bit per dimension |
| lnk_in_dst_i | input | DIM*DIM | Incoming destination, field k for dimension k |
| lnk_in_data_i | input | DIM*PW | Incoming payload, field k for dimension k |
| lnk_in_ready_o | output | DIM | Incoming link accepted |
| inj_valid_i | input | 1 | Local injection valid |
| inj_dst_i | input | DIM | Local injection destination |
| inj_data_i | input | PW | Local injection payload |
| inj_ready_o | output | 1 | Local injection accepted |
| lnk_out_valid_o | output | DIM | Outgoing message valid per dimension |
| lnk_out_dst_o | output | DIM*DIM | Outgoing destination per dimension |
| lnk_out_data_o | output | DIM*PW | Outgoing payload per dimension |
| lnk_out_ready_i | input | DIM | Neighbour accepts on that dimension |
| dlv_valid_o | output | 1 | Delivery message valid |
| dlv_dst_o | output | DIM | Delivery destination |
| dlv_data_o | output | PW | Delivery payload |
| dlv_ready_i | input | 1 | Local sink accepts delivery |
| hops_o | output | (DIM+1)*HW | Remaining hop count per input, HW = clog2(DIM+1) |

## Verification
The assertions assume that node_id_i stays constant after reset. They also assume that a sender keeps valid, destination and payload steady until the handshake completes, and that every destination is a node address of the cube. The bench builds an eight-node cube with each node wired to its neighbours by address. Each node injects from a queue that changes its signals only after an accepted transfer and only outside reset. Delivery ready follows a fixed staggered pattern, so the stalls stay bounded and every queue drains.

// File: rtl/hcube_pkg.sv
package hcube_pkg;
  localparam int MAX_DIM = 8;

  function automatic int ones(input logic [MAX_DIM-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < MAX_DIM; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/hcube_route.sv
module hcube_route import hcube_pkg::*; #(
  parameter int DIM = 3,
  localparam int HW = $clog2(DIM + 1)
) (
  input  logic [DIM-1:0] node_id_i,
  input  logic [DIM-1:0] dst_i,
  output logic [DIM:0]   tgt_o,
  output logic [HW-1:0]  hops_o
);
  logic [DIM-1:0]     diff_w;
  logic [DIM-1:0]     low_w;
  logic [MAX_DIM-1:0] wide_w;

  always_comb begin
    diff_w = node_id_i ^ dst_i;
    // isolate lowest set bit
    low_w  = diff_w & (~diff_w + DIM'(1));
    wide_w = '0;
    wide_w[DIM-1:0] = diff_w;
    tgt_o  = {(diff_w == '0), low_w};
    hops_o = HW'(ones(wide_w));
  end
endmodule

// File: rtl/hcube_out_slot.sv
module hcube_out_slot #(
  parameter int NIN = 4,
  parameter int DIM = 3,
  parameter int PW  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIN-1:0]   req_i,
  input  logic [NIN*DIM-1:0] dst_i,
  input  logic [NIN*PW-1:0]  data_i,
  output logic [NIN-1:0]   gnt_o,
  output logic             valid_o,
  output logic [DIM-1:0]   dst_o,
  output logic [PW-1:0]    data_o,
  input  logic             ready_i
);
  logic           full_q;
  logic [DIM-1:0] dst_q, dst_mux;
  logic [PW-1:0]  data_q, data_mux;

  // lowest-index requester wins, only into an empty slot
  assign gnt_o = full_q ? '0 : (req_i & (~req_i + NIN'(1)));

  always_comb begin
    dst_mux  = '0;
    data_mux = '0;
    for (int i = 0; i < NIN; i++) begin
      if (gnt_o[i]) begin
        dst_mux  = dst_mux  | dst_i[i*DIM +: DIM];
        data_mux = data_mux | data_i[i*PW +: PW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      dst_q  <= '0;
      data_q <= '0;
    end else if (full_q) begin
      if (ready_i) full_q <= 1'b0;
    end else if (|gnt_o) begin
      full_q <= 1'b1;
      dst_q  <= dst_mux;
      data_q <= data_mux;
    end
  end

  assign valid_o = full_q;
  assign dst_o   = dst_q;
  assign data_o  = data_q;
endmodule

// File: rtl/hcube_router.sv
module hcube_router import hcube_pkg::*; #(
  parameter int DIM = 3,
  parameter int PW  = 8,
  localparam int NP = DIM + 1,
  localparam int HW = $clog2(DIM + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIM-1:0]     node_id_i,
  input  logic [DIM-1:0]     lnk_in_valid_i,
  input  logic [DIM*DIM-1:0] lnk_in_dst_i,
  input  logic [DIM*PW-1:0]  lnk_in_data_i,
  output logic [DIM-1:0]     lnk_in_ready_o,
  input  logic               inj_valid_i,
  input  logic [DIM-1:0]     inj_dst_i,
  input  logic [PW-1:0]      inj_data_i,
  output logic               inj_ready_o,
  output logic [DIM-1:0]     lnk_out_valid_o,
  output logic [DIM*DIM-1:0] lnk_out_dst_o,
  output logic [DIM*PW-1:0]  lnk_out_data_o,
  input  logic [DIM-1:0]     lnk_out_ready_i,
  output logic               dlv_valid_o,
  output logic [DIM-1:0]     dlv_dst_o,
  output logic [PW-1:0]      dlv_data_o,
  input  logic               dlv_ready_i,
  output logic [NP*HW-1:0]   hops_o
);
  // input index DIM is injection, output index DIM is delivery
  logic [NP-1:0]     all_valid;
  logic [NP*DIM-1:0] all_dst;
  logic [NP*PW-1:0]  all_data;
  logic [NP-1:0]     in_rdy;
  logic [NP-1:0]     out_valid;
  logic [NP*DIM-1:0] out_dst;
  logic [NP*PW-1:0]  out_data;
  logic [NP-1:0]     out_ready;
  logic [NP-1:0]     tgt_m [NP];
  logic [NP-1:0]     req_m [NP];
  logic [NP-1:0]     gnt_m [NP];

  assign all_valid = {inj_valid_i, lnk_in_valid_i};
  assign all_dst   = {inj_dst_i, lnk_in_dst_i};
  assign all_data  = {inj_data_i, lnk_in_data_i};
  assign out_ready = {dlv_ready_i, lnk_out_ready_i};

  for (genvar i = 0; i < NP; i++) begin : g_in
    hcube_route #(.DIM(DIM)) u_route (
      .node_id_i (node_id_i),
      .dst_i     (all_dst[i*DIM +: DIM]),
      .tgt_o     (tgt_m[i]),
      .hops_o    (hops_o[i*HW +: HW])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) req_m[o][i] = all_valid[i] & tgt_m[i][o];
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    hcube_out_slot #(.NIN(NP), .DIM(DIM), .PW(PW)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_m[o]),
      .dst_i   (all_dst),
      .data_i  (all_data),
      .gnt_o   (gnt_m[o]),
      .valid_o (out_valid[o]),
      .dst_o   (out_dst[o*DIM +: DIM]),
      .data_o  (out_data[o*PW +: PW]),
      .ready_i (out_ready[o])
    );
  end

  always_comb begin
    in_rdy = '0;
    for (int o = 0; o < NP; o++) in_rdy = in_rdy | gnt_m[o];
  end

  assign lnk_in_ready_o  = in_rdy[DIM-1:0];
  assign inj_ready_o     = in_rdy[DIM];
  assign lnk_out_valid_o = out_valid[DIM-1:0];
  assign lnk_out_dst_o   = out_dst[DIM*DIM-1:0];
  assign lnk_out_data_o  = out_data[DIM*PW-1:0];
  assign dlv_valid_o     = out_valid[DIM];
  assign dlv_dst_o       = out_dst[DIM*DIM +: DIM];
  assign dlv_data_o      = out_data[DIM*PW +: PW];
endmodule

// File: rtl/hcube_router_chk.sv
module hcube_router_chk #(
  parameter int DIM = 3,
  parameter int PW  = 8,
  localparam int HW = $clog2(DIM + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DIM-1:0]     node_id_i,
  input logic [DIM-1:0]     lnk_in_valid_i,
  input logic [DIM-1:0]     lnk_in_ready_o,
  input logic               inj_valid_i,
  input logic [DIM-1:0]     inj_dst_i,
  input logic               inj_ready_o,
  input logic [DIM-1:0]     lnk_out_valid_o,
  input logic [DIM*DIM-1:0] lnk_out_dst_o,
  input logic [DIM*PW-1:0]  lnk_out_data_o,
  input logic [DIM-1:0]     lnk_out_ready_i,
  input logic               dlv_valid_o,
  input logic [DIM-1:0]     dlv_dst_o,
  input logic [PW-1:0]      dlv_data_o,
  input logic               dlv_ready_i,
  input logic [HW-1:0]      inj_hops_i
);
  p_dlv_local_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_dst_o == node_id_i));

  p_hops_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && inj_dst_i == node_id_i) |-> (inj_hops_i == '0));

  p_inj_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_ready_o |-> inj_valid_i);

  p_hold_dlv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && !dlv_ready_i) |=> (dlv_valid_o && $stable(dlv_data_o) && $stable(dlv_dst_o)));

  p_reset_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (lnk_out_valid_o == '0 && !dlv_valid_o));

  for (genvar k = 0; k < DIM; k++) begin : g_k
    localparam logic [DIM-1:0] LOW_MASK = DIM'((1 << k) - 1);
    logic [DIM-1:0] diff_w;
    assign diff_w = node_id_i ^ lnk_out_dst_o[k*DIM +: DIM];

    p_link_dim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lnk_out_valid_o[k] |-> (diff_w[k] && ((diff_w & LOW_MASK) == '0)));

    p_lnk_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lnk_in_ready_o[k] |-> lnk_in_valid_i[k]);

    p_hold_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lnk_out_valid_o[k] && !lnk_out_ready_i[k]) |=>
        (lnk_out_valid_o[k] && $stable(lnk_out_data_o[k*PW +: PW]) &&
         $stable(lnk_out_dst_o[k*DIM +: DIM])));
  end
endmodule

bind hcube_router hcube_router_chk #(.DIM(DIM), .PW(PW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .node_id_i       (node_id_i),
  .lnk_in_valid_i  (lnk_in_valid_i),
  .lnk_in_ready_o  (lnk_in_ready_o),
  .inj_valid_i     (inj_valid_i),
  .inj_dst_i       (inj_dst_i),
  .inj_ready_o     (inj_ready_o),
  .lnk_out_valid_o (lnk_out_valid_o),
  .lnk_out_dst_o   (lnk_out_dst_o),
  .lnk_out_data_o  (lnk_out_data_o),
  .lnk_out_ready_i (lnk_out_ready_i),
  .dlv_valid_o     (dlv_valid_o),
  .dlv_dst_o       (dlv_dst_o),
  .dlv_data_o      (dlv_data_o),
  .dlv_ready_i     (dlv_ready_i),
  .inj_hops_i      (hops_o[DIM*HW +: HW])
);

// File: tb/hcube_router_bench.sv
`timescale 1ns/1ps
module hcube_router_bench;
  localparam int DIM = 3;
  localparam int PW  = 8;
  localparam int N   = 1 << DIM;
  localparam int NP  = DIM + 1;
  localparam int HW  = $clog2(DIM + 1);
  localparam int QD  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  logic [N*DIM-1:0]     lo_v, lo_r, li_v, li_r;
  logic [N*DIM*DIM-1:0] lo_d, li_d;
  logic [N*DIM*PW-1:0]  lo_p, li_p;
  logic [N-1:0]         inj_v, inj_r, dlv_v, dlv_r;
  logic [N*DIM-1:0]     inj_d, dlv_d;
  logic [N*PW-1:0]      inj_p, dlv_p;
  logic [N*NP*HW-1:0]   hops;

  for (genvar n = 0; n < N; n++) begin : g_node
    for (genvar k = 0; k < DIM; k++) begin : g_lnk
      localparam int NB = n ^ (1 << k);
      assign li_v[n*DIM+k] = lo_v[NB*DIM+k];
      assign li_d[(n*DIM+k)*DIM +: DIM] = lo_d[(NB*DIM+k)*DIM +: DIM];
      assign li_p[(n*DIM+k)*PW +: PW]   = lo_p[(NB*DIM+k)*PW +: PW];
      assign lo_r[n*DIM+k] = li_r[NB*DIM+k];
    end
    hcube_router #(.DIM(DIM), .PW(PW)) u_hcube_router (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .node_id_i       (DIM'(n)),
      .lnk_in_valid_i  (li_v[n*DIM +: DIM]),
      .lnk_in_dst_i    (li_d[n*DIM*DIM +: DIM*DIM]),
      .lnk_in_data_i   (li_p[n*DIM*PW +: DIM*PW]),
      .lnk_in_ready_o  (li_r[n*DIM +: DIM]),
      .inj_valid_i     (inj_v[n]),
      .inj_dst_i       (inj_d[n*DIM +: DIM]),
      .inj_data_i      (inj_p[n*PW +: PW]),
      .inj_ready_o     (inj_r[n]),
      .lnk_out_valid_o (lo_v[n*DIM +: DIM]),
      .lnk_out_dst_o   (lo_d[n*DIM*DIM +: DIM*DIM]),
      .lnk_out_data_o  (lo_p[n*DIM*PW +: DIM*PW]),
      .lnk_out_ready_i (lo_r[n*DIM +: DIM]),
      .dlv_valid_o     (dlv_v[n]),
      .dlv_dst_o       (dlv_d[n*DIM +: DIM]),
      .dlv_data_o      (dlv_p[n*PW +: PW]),
      .dlv_ready_i     (dlv_r[n]),
      .hops_o          (hops[n*NP*HW +: NP*HW])
    );
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pop(input int v);
    int c = 0;
    for (int b = 0; b < DIM; b++) if (v[b]) c++;
    return c;
  endfunction

  function automatic int lsb(input int v);
    for (int b = 0; b < DIM; b++) if (v[b]) return b;
    return -1;
  endfunction

  // reference model state, message id = {phase, src[2:0], dst[2:0]}
  logic [PW-1:0] qmem [N][QD];
  int qlen [N], qhead [N];
  int hop_cnt [256], last_dim [256], dlv_cnt [256];
  bit injected [256];
  bit fire_q [N];
  bit hold_l [N*DIM];
  logic [PW-1:0] prev_l [N*DIM];
  bit hold_d [N];
  logic [PW-1:0] prev_d [N];
  int total = 0, ndel = 0, cyc = 0;
  bit timeout = 1'b0;

  // driver: advances after the edge at which a handshake completed
  always @(posedge clk) begin
    #1;
    for (int n = 0; n < N; n++) begin
      if (fire_q[n]) qhead[n]++;
      fire_q[n] = 1'b0;
      if (rst_n && qhead[n] < qlen[n]) begin
        inj_v[n] = 1'b1;
        inj_p[n*PW +: PW] = qmem[n][qhead[n]];
        inj_d[n*DIM +: DIM] = qmem[n][qhead[n]][DIM-1:0];
      end else begin
        inj_v[n] = 1'b0;
      end
      dlv_r[n] = rst_n && (((cyc + n) % 3) != 0);
    end
  end

  // monitor: everything seen here completes at the coming edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 20000) timeout = 1'b1;
      for (int n = 0; n < N; n++) begin
        for (int k = 0; k < DIM; k++) begin
          int idx, id, dst;
          idx = n*DIM + k;
          id  = int'(lo_p[idx*PW +: PW]);
          dst = id & 7;
          if (hold_l[idx]) begin
            chk(lo_v[idx] && lo_p[idx*PW +: PW] == prev_l[idx], "R6 link hold", id, int'(prev_l[idx]));
          end
          hold_l[idx] = lo_v[idx] && !lo_r[idx];
          prev_l[idx] = lo_p[idx*PW +: PW];
          if (lo_v[idx] && lo_r[idx]) begin
            chk(k == lsb(n ^ dst), "R2 link dimension", k, lsb(n ^ dst));
            chk(k > last_dim[id], "R4 ascending dimension", k, last_dim[id] + 1);
            last_dim[id] = k;
            hop_cnt[id]++;
          end
          if (li_v[idx]) begin
            chk(int'(hops[(n*NP+k)*HW +: HW]) == pop(n ^ int'(li_d[idx*DIM +: DIM])), "R3 link hops",
                int'(hops[(n*NP+k)*HW +: HW]), pop(n ^ int'(li_d[idx*DIM +: DIM])));
          end
        end
        if (inj_v[n]) begin
          chk(int'(hops[(n*NP+DIM)*HW +: HW]) == pop(n ^ int'(inj_d[n*DIM +: DIM])), "R3 inject hops",
              int'(hops[(n*NP+DIM)*HW +: HW]), pop(n ^ int'(inj_d[n*DIM +: DIM])));
          fire_q[n] = inj_r[n];
        end else begin
          chk(inj_r[n] == 1'b0, "R5 ready without valid", int'(inj_r[n]), 0);
        end
        if (hold_d[n]) begin
          chk(dlv_v[n] && dlv_p[n*PW +: PW] == prev_d[n], "R6 delivery hold", int'(dlv_p[n*PW +: PW]), int'(prev_d[n]));
        end
        hold_d[n] = dlv_v[n] && !dlv_r[n];
        prev_d[n] = dlv_p[n*PW +: PW];
        if (dlv_v[n] && dlv_r[n]) begin
          int id, src, dst;
          id  = int'(dlv_p[n*PW +: PW]);
          src = (id >> 3) & 7;
          dst = id & 7;
          chk(dst == n, "R1 delivered at destination", n, dst);
          chk(int'(dlv_d[n*DIM +: DIM]) == n, "R1 delivery dst field", int'(dlv_d[n*DIM +: DIM]), n);
          chk(hop_cnt[id] == pop(src ^ dst), "R4 hop count", hop_cnt[id], pop(src ^ dst));
          chk(injected[id] && dlv_cnt[id] == 0, "R5 single delivery", dlv_cnt[id], 0);
          dlv_cnt[id]++;
          ndel++;
        end
      end
    end
  end

  task automatic add_msg(input int ph, input int src, input int dst);
    int id;
    id = (ph << 6) | (src << 3) | dst;
    qmem[src][qlen[src]] = PW'(id);
    qlen[src]++;
    injected[id] = 1'b1;
    total++;
  endtask

  initial begin
    inj_v = '0; inj_d = '0; inj_p = '0; dlv_r = '0;
    for (int i = 0; i < 256; i++) begin
      hop_cnt[i] = 0; last_dim[i] = -1; dlv_cnt[i] = 0; injected[i] = 1'b0;
    end
    for (int n = 0; n < N; n++) begin
      qlen[n] = 0; qhead[n] = 0; fire_q[n] = 1'b0; hold_d[n] = 1'b0; prev_d[n] = '0;
    end
    for (int i = 0; i < N*DIM; i++) begin hold_l[i] = 1'b0; prev_l[i] = '0; end
    // permutation rounds: every pair, including self
    for (int d = 0; d < N; d++)
      for (int n = 0; n < N; n++) add_msg(0, n, (n + d) % N);
    // hot spots at the two opposite corners
    for (int n = 0; n < N; n++) begin add_msg(1, n, 0); add_msg(1, n, N-1); end

    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lo_v == '0, "R7 link valids in reset", int'(lo_v != '0), 0);
    chk(dlv_v == '0, "R7 delivery valids in reset", int'(dlv_v), 0);
    rst_n = 1'b1;
    wait (ndel == total || timeout);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 256; i++)
      if (injected[i]) chk(dlv_cnt[i] == 1, "R5 every message delivered", dlv_cnt[i], 1);
    chk(ndel == total, "R5 delivery total", ndel, total);
    if (timeout) chk(1'b0, "watchdog", cyc, 20000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule